// File: doc/BRIEF.md
# Zero-turnaround pipelined SRAM

A single-port synchronous memory whose reads and writes share one fixed pipeline length, so that any mix of the two can be issued on consecutive enabled clocks without dead cycles. A command (address, write strobe, per-lane write masks and the three chip enables) is sampled on a rising edge. A read returns its word on the registered data output two enabled edges later. A write takes its data from the data input at the same position, two enabled edges after its address, so read and write data slots never collide on the shared data bus.

The data bus is modelled as separate input, output and drive-enable signals. The drive enable is high only for the data slot of a read, and only while the asynchronous output-enable input is low. It is low for write slots, for slots whose command found the device deselected, and during reset. A high clock-enable input freezes every register in the block, including the output, without deselecting it. Captured write data waits one more enabled edge in a holding register before it reaches the array. A read that lands in that gap takes the pending lanes from the holding register, so the gap is invisible outside the block.

The default geometry is 64 words of four 9-bit lanes, each lane 8 data bits plus 1 parity bit. Burst addressing is done by a separate block.

Top module: `zt_sram`

## Requirements
- R1: While rst_n is low, dout_en is 0. After reset, dout is all zeros until the first read slot.
- R2: A read (device selected, wr_n=1) sampled on an enabled edge puts the addressed word on dout on the second enabled edge after it. dout_en is high for exactly that slot when oe_n is low.
- R3: For a write (device selected, wr_n=0), din is captured on the second enabled edge after the address. din at every other edge has no effect on memory contents.
- R4: Lane i is bits [9i+8:9i] of din and dout. A write changes lane i only when lane_sel_n[i] was 0 at the address edge. Other lanes keep their old contents.
- R5: Reads and writes can be issued on every enabled cycle in any order. A read issued on the enabled cycle right after a write to the same address, or any later cycle, returns the written lanes merged with the old unwritten lanes.
- R6: The device is selected only when ce1_n=0, ce2=1 and ce3_n=0. Any other combination makes that slot a no-operation: no array change and no drive.
- R7: When clk_en_n is 1 at an edge, no command or data is sampled, and dout, the drive state and all pipeline contents hold.
- R8: dout_en is 0 during write slots and no-operation slots whatever the level of oe_n. During a read slot it follows oe_n combinationally (dout_en = not oe_n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Active-low write command |
| addr | input | ADDR_W | Word address |
| lane_sel_n | input | LANES | Active-low per-lane write mask |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, sampled in the write data slot |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
The properties assume that every control input holds a known level at each sampled edge after reset, and that clk_en_n is the only thing that pauses the pipeline. They also assume oe_n affects nothing but the final drive gate. The stimulus changes all inputs only on the falling clock edge, never leaves a pin undriven, and toggles oe_n inside a cycle only for the drive-gating case. Random traffic keeps to a handful of addresses so that write-then-read hazards through the holding register happen often. Freeze cycles and deselect patterns are mixed in at fixed rates.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zt_op_e;

  function automatic zt_op_e decode_op(input logic sel, input logic wr_n);
    if (!sel)      return OP_NONE;
    else if (wr_n) return OP_READ;
    else           return OP_WRITE;
  endfunction

endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  zt_op_e           op_in,
  input  logic [AW-1:0]    addr_in,
  input  logic [LANES-1:0] ben_in,
  output zt_op_e           op_head,
  output zt_op_e           op_tail,
  output logic [AW-1:0]    addr_tail,
  output logic [LANES-1:0] ben_tail
);

  zt_op_e           op_q   [LAT];
  logic [AW-1:0]    addr_q [LAT];
  logic [LANES-1:0] ben_q  [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) op_q[s] <= OP_NONE;
    end else if (adv) begin
      op_q[0] <= op_in;
      for (int s = 1; s < LAT; s++) op_q[s] <= op_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      addr_q[0] <= addr_in;
      ben_q[0]  <= ben_in;
      for (int s = 1; s < LAT; s++) begin
        addr_q[s] <= addr_q[s-1];
        ben_q[s]  <= ben_q[s-1];
      end
    end
  end

  assign op_head   = op_q[0];
  assign op_tail   = op_q[LAT-1];
  assign addr_tail = addr_q[LAT-1];
  assign ben_tail  = ben_q[LAT-1];

endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                wr_go,
  input  logic [AW-1:0]       wr_addr,
  input  logic [LANES-1:0]    wr_ben,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [LANES*LW-1:0] rd_data,
  output logic                hold_v
);

  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    hold_a;
  logic [LANES-1:0] hold_b;
  logic [DW-1:0]    hold_d;
  logic             hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hold_v <= 1'b0;
    else if (adv) hold_v <= wr_go;
  end

  always_ff @(posedge clk) begin
    if (adv && wr_go) begin
      hold_a <= wr_addr;
      hold_b <= wr_ben;
      hold_d <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && hold_v) begin
      for (int l = 0; l < LANES; l++) begin
        if (hold_b[l]) mem[hold_a][l*LW +: LW] <= hold_d[l*LW +: LW];
      end
    end
  end

  assign hit = hold_v && (hold_a == rd_addr);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
      assign rd_data[l*LW +: LW] = (hit && hold_b[l]) ? hold_d[l*LW +: LW]
                                                      : mem[rd_addr][l*LW +: LW];
    end
  endgenerate

endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          rd_go,
  input  logic [DW-1:0] rd_data,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          drv
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      drv  <= 1'b0;
    end else if (adv) begin
      drv <= rd_go;
      if (rd_go) dout <= rd_data;
    end
  end

  assign dout_en = drv & ~oe_n;

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int LAT    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en_n,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         lane_sel_n,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  logic              adv;
  logic              sel;
  zt_op_e            op_in;
  zt_op_e            op_head;
  zt_op_e            op_tail;
  logic [ADDR_W-1:0] addr_tail;
  logic [LANES-1:0]  ben_tail;
  logic [DATA_W-1:0] rd_data;
  logic              hold_v;
  logic              drv_q;

  assign adv   = ~clk_en_n;
  assign sel   = ~ce1_n & ce2 & ~ce3_n;
  assign op_in = decode_op(sel, wr_n);

  zt_cmd_pipe #(.AW(ADDR_W), .LANES(LANES), .LAT(LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .op_in     (op_in),
    .addr_in   (addr),
    .ben_in    (~lane_sel_n),
    .op_head   (op_head),
    .op_tail   (op_tail),
    .addr_tail (addr_tail),
    .ben_tail  (ben_tail)
  );

  zt_store #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .wr_go   (op_tail == OP_WRITE),
    .wr_addr (addr_tail),
    .wr_ben  (ben_tail),
    .wr_data (din),
    .rd_addr (addr_tail),
    .rd_data (rd_data),
    .hold_v  (hold_v)
  );

  zt_out_stage #(.DW(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .rd_go   (op_tail == OP_READ),
    .rd_data (rd_data),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_en (dout_en),
    .drv     (drv_q)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel,
  input zt_op_e        op_head,
  input zt_op_e        op_tail,
  input logic          drv,
  input logic          hold_v,
  input logic          dout_en,
  input logic [DW-1:0] dout
);

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!dout_en); // R1
    end
  end

  AST_READ_SLOT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (!clk_en_n && op_tail == OP_READ) |=> drv); // R2
  AST_WRITE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!clk_en_n && op_tail == OP_WRITE) |=> hold_v); // R3
  AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (!rst_n) (!clk_en_n && !sel) |=> (op_head == OP_NONE)); // R6
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) clk_en_n |=> ($stable(dout) && $stable(drv) && $stable(op_head) && $stable(op_tail))); // R7
  AST_WRITE_SLOT_DARK: assert property (@(posedge clk) disable iff (!rst_n) (!clk_en_n && op_tail != OP_READ) |=> !dout_en); // R8

endmodule

bind zt_sram zt_sram_chk #(.DW(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en_n (clk_en_n),
  .sel      (sel),
  .op_head  (op_head),
  .op_tail  (op_tail),
  .drv      (drv_q),
  .hold_v   (hold_v),
  .dout_en  (dout_en),
  .dout     (dout)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;

  localparam int AW    = 6;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clk_en_n = 1'b0;
  logic             ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic             wr_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [LANES-1:0] lane_sel_n = '1;
  logic             oe_n = 1'b0;
  logic [DW-1:0]    din = '0;
  logic [DW-1:0]    dout;
  logic             dout_en;

  int nchk = 0;
  int nfail = 0;
  string cur_tag = "R2";

  logic [DW-1:0]    mem_m [DEPTH];
  int               p1_op = 0, p2_op = 0;
  logic [AW-1:0]    p1_addr = '0, p2_addr = '0;
  logic [LANES-1:0] p1_ben = '0, p2_ben = '0;
  logic             exp_drv = 1'b0;
  logic [DW-1:0]    exp_dout = '0;

  always #5 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW), .LAT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .wr_n(wr_n), .addr(addr), .lane_sel_n(lane_sel_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [DW-1:0] rnd_data();
    return DW'({$urandom(), $urandom()});
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] ben);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++)
      if (ben[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic cen_n, input logic c1n, input logic c2,
                     input logic c3n, input logic wn, input logic [AW-1:0] a,
                     input logic [LANES-1:0] bsn, input logic oen);
    logic en;
    logic sel;
    logic [DW-1:0] wd;
    en  = !cen_n;
    sel = !c1n && c2 && !c3n;
    wd  = rnd_data();
    @(negedge clk);
    clk_en_n = cen_n; ce1_n = c1n; ce2 = c2; ce3_n = c3n; wr_n = wn;
    addr = a; lane_sel_n = bsn; oe_n = oen; din = wd;
    @(posedge clk);
    #1;
    if (en) begin
      if (p2_op == 2) mem_m[p2_addr] = merge(mem_m[p2_addr], wd, p2_ben);
      exp_drv = (p2_op == 1);
      if (p2_op == 1) exp_dout = mem_m[p2_addr];
      p2_op = p1_op; p2_addr = p1_addr; p2_ben = p1_ben;
      p1_op = !sel ? 0 : (wn ? 1 : 2);
      p1_addr = a; p1_ben = ~bsn;
    end
    chk(dout_en == (exp_drv && !oen), cur_tag, "dout_en", 64'(dout_en), 64'(exp_drv && !oen));
    if (exp_drv) chk(dout == exp_dout, cur_tag, "dout", 64'(dout), 64'(exp_dout));
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, '1, 1'b0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] bsn);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, bsn, 1'b0);
  endtask

  task automatic nop();
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '0, '1, 1'b0);
  endtask

  task automatic frz();
    cyc(1'b1, $urandom_range(1), $urandom_range(1), $urandom_range(1),
        $urandom_range(1), AW'($urandom()), LANES'($urandom()), 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=%h exp=%h", 64'd0, 64'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(dout_en == 1'b0, "R1", "dout_en in reset", 64'(dout_en), 64'd0);
    chk(dout == '0, "R1", "dout in reset", 64'(dout), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dout_en == 1'b0, "R1", "dout_en after reset", 64'(dout_en), 64'd0);

    // fill every word with full-lane writes
    cur_tag = "R3";
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0);
    nop(); nop();
    for (int a = 0; a < 8; a++) rd(AW'(a));
    nop(); nop();

    // R4: partial lane writes
    cur_tag = "R4";
    wr(6'd10, 4'b1010); nop(); nop(); nop();
    rd(6'd10); wr(6'd11, 4'b0110); nop(); nop(); rd(6'd11); nop(); nop();

    // R5: write then read next cycle and the one after, alternating
    cur_tag = "R5";
    wr(6'd20, 4'b0101); rd(6'd20); rd(6'd20);
    wr(6'd20, 4'b1100); rd(6'd20); wr(6'd21, 4'b0000); rd(6'd21); rd(6'd20);
    nop(); nop();

    // R6: each deselect pattern with a write command, then read back
    cur_tag = "R6";
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd30, '0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd30, '0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd30, '0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'd30, '1, 1'b0);
    rd(6'd30); nop(); nop();

    // R7: freeze between address and data phases of reads and writes
    cur_tag = "R7";
    wr(6'd40, 4'b0011); frz(); frz(); rd(6'd40); frz(); nop(); frz(); frz(); nop(); frz();
    rd(6'd40); nop(); nop(); frz(); frz();
    chk(dout == exp_dout, "R7", "dout held while frozen", 64'(dout), 64'(exp_dout));

    // R8: oe_n gating and write slot darkness
    cur_tag = "R8";
    rd(6'd41); nop(); nop();
    @(negedge clk);
    oe_n = 1'b1; #1;
    chk(dout_en == 1'b0, "R8", "oe_n high blocks drive", 64'(dout_en), 64'd0);
    oe_n = 1'b0; #1;
    chk(dout_en == 1'b1, "R8", "oe_n low allows drive", 64'(dout_en), 64'd1);
    wr(6'd42, '0); nop();
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, '0, '1, 1'b0);
    nop(); nop();

    // R2: constrained random mixed traffic
    cur_tag = "R2";
    for (int i = 0; i < 800; i++) begin
      logic cn, c1n, c2, c3n;
      cn = ($urandom_range(4) == 0);
      if ($urandom_range(7) == 0) begin
        c1n = $urandom_range(1); c2 = $urandom_range(1); c3n = $urandom_range(1);
      end else begin
        c1n = 1'b0; c2 = 1'b1; c3n = 1'b0;
      end
      cyc(cn, c1n, c2, c3n, $urandom_range(1), AW'($urandom_range(5)),
          LANES'($urandom()), ($urandom_range(5) == 0));
    end
    nop(); nop(); nop();

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule